// File: doc/BRIEF.md
# Single-Wire Serial Bus Master (HDQ and 1-Wire)

This block is a register-mapped master for a single open-drain serial line. It can speak either of two line protocols: HDQ or 1-Wire. Software loads a byte and writes the control register with GO set. The block then runs one operation on the line: a break with presence detection, a byte transmit, a byte receive, or a one-bit transfer. When the operation ends, the block clears GO, latches a completion or timeout flag, and raises its interrupt if enabled.

The block pulls the line low through `line_oe`, which goes to an external open-drain pad, and it reads the line back on `line_in`. Every line time is a parameter counted in clock ticks. Bits go out least significant first. In 1-Wire mode the master opens every slot. In HDQ receive the master stays quiet and each bit starts at the slave's falling edge. If no slave edge arrives within a limit, the receive is abandoned.

Top module: `owb_master`

## Requirements
- R1: After reset, control, interrupt status, transmit and receive data read 0, `line_oe` and `irq` are low, and word 0 reads {REV_MAJOR[3:0], REV_MINOR[3:0]}.
- R2: Registers sit at word indices 0 revision, 1 transmit data, 2 receive data, 3 control, 4 interrupt status. Transmit data reads back what was written.
- R3: Control bits: 0 protocol (1 = 1-Wire, 0 = HDQ), 1 direction (1 = receive), 2 break, 3 presence (read-only), 4 GO, 5 clock enable, 6 interrupt enable, 7 single bit. Writing break, GO and clock enable together drives the line low for RST_LO ticks. PDS ticks after release the block samples the line into presence (1 = slave held it low). At RST_TOT the block sets status bit 0 and clears GO and break.
- R4: A transmit (direction 0) sends the transmit byte LSB first in 1-Wire mode, one slot per bit. A 1 bit is a low pulse of W_W1 ticks and a 0 bit a low pulse of W_W0 ticks. At the end, status bit 2 is set and GO clears.
- R5: A 1-Wire receive (direction 1) starts each slot with a W_RDLO-tick low pulse and samples the line W_RDSMP ticks into the slot, LSB first. It stores the byte in receive data, sets status bit 1 and clears GO.
- R6: With single bit set, one slot is run. A transmit sends transmit data bit 0. A receive puts the bit in receive data bit 0 with bits 7:1 zero.
- R7: In HDQ mode, transmit uses H_W1/H_W0 low pulses. Receive never drives the line: each bit starts at the slave's falling edge and is sampled H_RDSMP ticks later.
- R8: An HDQ receive with no slave falling edge for RX_TMO ticks sets status bit 0 and clears GO. It sets no receive-complete flag and leaves receive data unchanged.
- R9: Reading interrupt status returns the latched flags and clears them.
- R10: `irq` is high exactly when interrupt enable is set and any status flag is latched.
- R11: GO written with clock enable clear reads back 0 and causes no line activity. Control writes while an operation runs are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all line times count its ticks |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 3 | Register word index (byte offset / 4) |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears status on index 4) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from reg_sel |
| irq | output | 1 | Interrupt request |
| line_oe | output | 1 | 1 = pull the bus line low |
| line_in | input | 1 | Resolved level of the bus line |

## Verification
The checks assume that `line_in` is the resolved wired-AND level, so the line is low whenever `line_oe` is high. They also assume that a slave pulls the line only inside the windows the protocol leaves for it. The bench models such a slave: it answers 1-Wire slots with pulls that cover the sample point and end before the slot ends. Its HDQ replies start well after the master has returned to waiting. Its presence pulses start shortly after the break is released.

// File: rtl/owb_master.sv
module owb_master #(
  parameter int REV_MAJOR = 2,
  parameter int REV_MINOR = 1,
  parameter int W_RST_LO  = 120000,
  parameter int W_PDS     = 17500,
  parameter int W_RST_TOT = 240000,
  parameter int W_SLOT    = 16250,
  parameter int W_W1      = 1500,
  parameter int W_W0      = 15000,
  parameter int W_RDLO    = 1500,
  parameter int W_RDSMP   = 3750,
  parameter int H_RST_LO  = 47500,
  parameter int H_PDS     = 12500,
  parameter int H_RST_TOT = 62500,
  parameter int H_SLOT    = 47500,
  parameter int H_W1      = 12500,
  parameter int H_W0      = 30000,
  parameter int H_RDSMP   = 25000,
  parameter int RX_TMO    = 250000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] reg_sel,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq,
  output logic       line_oe,
  input  logic       line_in
);
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
  localparam int TMAX = mx(mx(W_RST_TOT, H_RST_TOT), mx(mx(W_SLOT, H_SLOT), RX_TMO));
  localparam int CW   = $clog2(TMAX + 1);

  typedef enum logic [1:0] {S_IDLE, S_BRK, S_SLOT} st_t;
  st_t st;
  logic [7:0] ctrl, txd, rxd, sh;
  logic [2:0] ist, bitn;
  logic [CW-1:0] cnt;
  logic wt;

  wire w1   = ctrl[0];
  wire dir  = ctrl[1];
  wire sgl  = ctrl[7];
  wire [2:0] last = sgl ? 3'd0 : 3'd7;
  wire [CW-1:0] t_rlo  = w1 ? CW'(W_RST_LO)  : CW'(H_RST_LO);
  wire [CW-1:0] t_pds  = w1 ? CW'(W_PDS)     : CW'(H_PDS);
  wire [CW-1:0] t_tot  = w1 ? CW'(W_RST_TOT) : CW'(H_RST_TOT);
  wire [CW-1:0] t_slot = w1 ? CW'(W_SLOT)    : CW'(H_SLOT);
  wire [CW-1:0] t_w1   = w1 ? CW'(W_W1)      : CW'(H_W1);
  wire [CW-1:0] t_w0   = w1 ? CW'(W_W0)      : CW'(H_W0);
  wire [CW-1:0] t_smp  = w1 ? CW'(W_RDSMP)   : CW'(H_RDSMP);
  wire start = wr_en && reg_sel == 3'd3 && st == S_IDLE && wdata[4] && wdata[5];

  assign irq = ctrl[6] && (ist != 3'b0);

  always_comb begin
    line_oe = 1'b0;
    if (st == S_BRK) line_oe = cnt < t_rlo;
    else if (st == S_SLOT && !wt) begin
      if (dir) line_oe = w1 && cnt < CW'(W_RDLO);
      else     line_oe = cnt < (sh[0] ? t_w1 : t_w0);
    end
  end

  always_comb begin
    case (reg_sel)
      3'd0:    rdata = {4'(REV_MAJOR), 4'(REV_MINOR)};
      3'd1:    rdata = txd;
      3'd2:    rdata = rxd;
      3'd3:    rdata = ctrl;
      3'd4:    rdata = {5'b0, ist};
      default: rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ctrl <= '0; txd <= '0; rxd <= '0; sh <= '0;
      ist <= '0; bitn <= '0; cnt <= '0; wt <= 1'b0;
    end else begin
      if (rd_en && reg_sel == 3'd4) ist <= '0;
      if (wr_en && reg_sel == 3'd1) txd <= wdata;
      if (wr_en && reg_sel == 3'd3 && st == S_IDLE)
        ctrl <= {wdata[7:5], wdata[4] & wdata[5], ctrl[3], wdata[2:0]};
      if (start) begin
        cnt <= '0; bitn <= '0; sh <= txd;
        if (wdata[2]) st <= S_BRK;
        else begin st <= S_SLOT; wt <= wdata[1] & ~wdata[0]; end
      end
      case (st)
        S_BRK: begin
          cnt <= cnt + 1'b1;
          if (cnt == t_rlo + t_pds) ctrl[3] <= !line_in;
          if (cnt == t_tot - 1'b1) begin
            st <= S_IDLE; ctrl[4] <= 1'b0; ctrl[2] <= 1'b0; ist[0] <= 1'b1;
          end
        end
        S_SLOT: begin
          if (wt) begin
            if (!line_in) begin wt <= 1'b0; cnt <= CW'(1); end
            else if (cnt == CW'(RX_TMO - 1)) begin
              st <= S_IDLE; ctrl[4] <= 1'b0; ist[0] <= 1'b1; wt <= 1'b0; cnt <= '0;
            end else cnt <= cnt + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
            if (dir && cnt == t_smp) sh <= {line_in, sh[7:1]};
            if (cnt == t_slot - 1'b1) begin
              cnt <= '0;
              bitn <= bitn + 1'b1;
              if (!dir) sh <= {1'b0, sh[7:1]};
              wt <= dir & ~w1;
              if (bitn == last) begin
                st <= S_IDLE; ctrl[4] <= 1'b0; wt <= 1'b0;
                if (dir) begin
                  ist[1] <= 1'b1;
                  rxd <= sgl ? {7'b0, sh[7]} : sh;
                end else ist[2] <= 1'b1;
              end
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R3
  pres_only_brk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl[3]) |-> $past(st) == S_BRK);
  // R4 R5 R8
  go_done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl[4]) |-> ist != 3'b0);
  // R11
  go_needs_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[4] |-> ctrl[5]);
  // R7
  hdq_rx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SLOT && dir && !w1) |-> !line_oe);
  // R6
  single_one_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SLOT && sgl) |-> bitn == 3'd0);
endmodule

// File: tb/owb_master_test.sv
module owb_master_test;
  localparam int WRL = 40, WPD = 10, WRT = 100, WSL = 30, WW1 = 3, WW0 = 20, WRDL = 2, WRDS = 8;
  localparam int HRL = 50, HPD = 12, HRT = 110, HSL = 40, HW1 = 5, HW0 = 25, HRDS = 15, TMO = 200;
  localparam int MAJ = 3, MIN = 7;

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [2:0] reg_sel = 0;
  logic [7:0] wdata = 0, rdata;
  logic irq, line_oe, line_in;
  logic pull_p = 0, pull_r = 0, hpull = 0;
  assign line_in = ~(line_oe | pull_p | pull_r | hpull);

  owb_master #(.REV_MAJOR(MAJ), .REV_MINOR(MIN),
    .W_RST_LO(WRL), .W_PDS(WPD), .W_RST_TOT(WRT), .W_SLOT(WSL), .W_W1(WW1), .W_W0(WW0),
    .W_RDLO(WRDL), .W_RDSMP(WRDS), .H_RST_LO(HRL), .H_PDS(HPD), .H_RST_TOT(HRT),
    .H_SLOT(HSL), .H_W1(HW1), .H_W0(HW0), .H_RDSMP(HRDS), .RX_TMO(TMO)) uut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .irq(irq), .line_oe(line_oe), .line_in(line_in));

  always #2 clk = ~clk;

  int n_run = 0, n_fail = 0;
  logic cur_w1 = 1, pres_en = 0, rx1w_en = 0, fin = 0;
  logic [7:0] sl_byte = 0, cap = 0;
  int ncap = 0, nrise = 0, sl_i = 0, sl_base = 0, hi_run = 0, pres_cnt = 0, rd_cnt = 0;
  logic prev_oe = 0;

  always @(negedge clk) begin
    if (line_oe) hi_run++;
    if (!prev_oe && line_oe) begin
      nrise++;
      if (rx1w_en) begin
        if (!sl_byte[(sl_i - sl_base) % 8]) rd_cnt = 12;
        sl_i++;
      end
    end
    if (prev_oe && !line_oe) begin
      if (hi_run >= 35) begin if (pres_en) pres_cnt = 32; end
      else if (hi_run == (cur_w1 ? WW1 : HW1)) begin cap = {1'b1, cap[7:1]}; ncap++; end
      else if (hi_run == (cur_w1 ? WW0 : HW0)) begin cap = {1'b0, cap[7:1]}; ncap++; end
      hi_run = 0;
    end
    prev_oe = line_oe;
    pull_p = pres_cnt > 0 && pres_cnt <= 28;
    if (pres_cnt > 0) pres_cnt--;
    pull_r = rd_cnt > 0;
    if (rd_cnt > 0) rd_cnt--;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bwr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_sel = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic brd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_sel = a; rd_en = 1; #1 d = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic wait_done();
    logic [7:0] c;
    for (int k = 0; k < 3000; k++) begin
      brd(3'd3, c);
      if (!c[4]) break;
    end
  endtask

  task automatic hdq_send(input logic [7:0] b, input int nb);
    for (int i = 0; i < nb; i++) begin
      repeat (4) @(negedge clk);
      hpull = 1;
      repeat (b[i] ? 3 : 20) @(negedge clk);
      hpull = 0;
      repeat (HSL) @(negedge clk);
    end
  endtask

  function automatic logic [7:0] exp_rev();
    return {4'(MAJ), 4'(MIN)};
  endfunction

  function automatic logic [7:0] exp_single(input logic [7:0] b);
    return {7'b0, b[0]};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, b;
    int n0;
    void'($urandom(32'h5eed_0b1));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    brd(3'd3, d); chk("R1 ctrl", d, 0);
    brd(3'd4, d); chk("R1 status", d, 0);
    brd(3'd2, d); chk("R1 rxdata", d, 0);
    chk("R1 line_oe", line_oe, 0);
    chk("R1 irq", irq, 0);
    brd(3'd0, d); chk("R1 revision", d, exp_rev());
    // R2 transmit data readback
    bwr(3'd1, 8'hA5); brd(3'd1, d); chk("R2 txdata", d, 8'hA5);

    // R11 GO ignored without clock enable
    n0 = nrise;
    bwr(3'd3, 8'h11);
    repeat (60) @(negedge clk);
    brd(3'd3, d); chk("R11 go without clken", d[4], 0);
    chk("R11 no line activity", nrise - n0, 0);

    // R3 break with presence, R10 irq, R9 clear-on-read
    pres_en = 1; cur_w1 = 1;
    bwr(3'd3, 8'h75); wait_done();
    brd(3'd3, d);
    chk("R3 go/init cleared", d & 8'h14, 0);
    chk("R3 presence seen", d[3], 1);
    chk("R10 irq on flag", irq, 1);
    brd(3'd4, d); chk("R3 timeout flag", d, 1);
    brd(3'd4, d); chk("R9 cleared by read", d, 0);
    chk("R10 irq after clear", irq, 0);
    // R3 break without presence
    pres_en = 0;
    bwr(3'd3, 8'h35); wait_done();
    brd(3'd3, d); chk("R3 presence absent", d[3], 0);
    brd(3'd4, d); chk("R3 timeout flag no slave", d, 1);

    // R4 random 1-Wire transmits, R11 write while busy
    for (int i = 0; i < 6; i++) begin
      b = 8'($urandom);
      if (i == 0) b = 8'hFF;
      if (i == 1) b = 8'h00;
      bwr(3'd1, b); n0 = ncap;
      bwr(3'd3, 8'h31);
      if (i == 2) bwr(3'd3, 8'h00);
      wait_done();
      chk("R4 tx bit count", ncap - n0, 8);
      chk("R4 tx byte", cap, b);
      brd(3'd4, d); chk("R4 tx done flag", d, 4);
      if (i == 2) begin
        brd(3'd3, d); chk("R11 busy write ignored", d & 8'hF7, 8'h21);
      end
    end

    // R5 random 1-Wire receives
    for (int i = 0; i < 6; i++) begin
      b = 8'($urandom);
      if (i == 0) b = 8'h00;
      sl_byte = b; sl_base = sl_i; rx1w_en = 1;
      bwr(3'd3, 8'h33); wait_done(); rx1w_en = 0;
      brd(3'd2, d); chk("R5 rx byte", d, b);
      brd(3'd4, d); chk("R5 rx done flag", d, 2);
    end

    // R6 single-bit transmit and receive
    for (int i = 0; i < 2; i++) begin
      b = 8'($urandom) ^ 8'(i);
      bwr(3'd1, b); n0 = ncap;
      bwr(3'd3, 8'hB1); wait_done();
      chk("R6 single tx slots", ncap - n0, 1);
      chk("R6 single tx bit", cap[7], b[0]);
      sl_byte = {7'h7F, 1'(i)}; sl_base = sl_i; rx1w_en = 1;
      bwr(3'd3, 8'hB3); wait_done(); rx1w_en = 0;
      brd(3'd2, d); chk("R6 single rx", d, exp_single(sl_byte));
      brd(3'd4, d); chk("R6 single done flags", d, 6);
    end

    // R7 HDQ transmit and receive
    cur_w1 = 0;
    for (int i = 0; i < 3; i++) begin
      b = 8'($urandom);
      bwr(3'd1, b); n0 = ncap;
      bwr(3'd3, 8'h30); wait_done();
      chk("R7 hdq tx bit count", ncap - n0, 8);
      chk("R7 hdq tx byte", cap, b);
      b = 8'($urandom);
      n0 = nrise;
      bwr(3'd3, 8'h32); hdq_send(b, 8); wait_done();
      chk("R7 hdq rx quiet", nrise - n0, 0);
      brd(3'd2, d); chk("R7 hdq rx byte", d, b);
      brd(3'd4, d); chk("R7 hdq flags", d, 6);
    end

    // R8 HDQ receive timeout
    brd(3'd2, b);
    bwr(3'd3, 8'h32); wait_done();
    brd(3'd3, d); chk("R8 go cleared", d[4], 0);
    brd(3'd4, d); chk("R8 timeout only", d, 1);
    brd(3'd2, d); chk("R8 rxdata kept", d, b);

    // R10 interrupt gating
    cur_w1 = 1;
    bwr(3'd1, 8'h3C); bwr(3'd3, 8'h31); wait_done();
    chk("R10 irq masked", irq, 0);
    bwr(3'd3, 8'h61);
    @(negedge clk); chk("R10 irq enabled", irq, 1);
    brd(3'd4, d); chk("R9 status value", d, 4);
    chk("R10 irq cleared", irq, 0);

    fin = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule